// File: doc/BRIEF.md
# Boot Processor Election Node

Each processing node in a multi-node system carries one copy of this controller. After reset, every node with a legal identifier waits for its built-in self-test to finish. It then places one election broadcast on the shared message bus. The bus is addressed to every node, including the sender. The bus arbiter serializes all broadcasts, and every node observes them in the same order. The first valid election message a node sees settles its role. The node whose identifier matches the sender identifier carried in that message becomes the boot processor. Every other node becomes an application processor and waits to be started.

The boot processor then broadcasts a final boot message, again to everyone including itself. It raises its firmware-start output only when that message comes back on the bus. Because the bus is serialized, any election broadcasts that were queued earlier have drained by that point. An application processor ignores the final boot message. It waits for a startup message, records the 8-bit start vector carried in it, and signals the start with a single-cycle pulse. The controller contains no arbitration logic of its own; arrival order on the bus is the only thing that decides the election.

Top module: `boot_elect_node`

## Requirements
- R1: While reset is asserted and just after it is released, `is_bsp`, `is_ap`, `start_fw`, `start_ap` and `tx_req` are 0, and `ap_vector` is 00h.
- R2: Once `bist_done` is high and `node_id` is not Fh, the node requests exactly one election message. That message has type 0, vector {4h, node_id} and delivery mode 000.
- R3: A node whose `node_id` is Fh never raises `tx_req` for an election message. Vector 4Fh is therefore never sent.
- R4: A node takes its role from the first valid election message. If the low nibble of the vector equals `node_id`, the node sets `is_bsp`; otherwise it sets `is_ap`. Later election messages do not change the role.
- R5: An election message is valid only if all of the following hold: its vector high nibble is 4h, its low nibble is not Fh, `rx_src` equals that low nibble, and `rx_dmode` is 000. Any other election message leaves the node undecided.
- R6: After winning, the boot processor requests one final boot message with type 1, vector 10h and delivery mode 000.
- R7: `start_fw` rises only on the boot processor, and only after a final boot message (type 1, vector 10h, mode 000) has been received. Once high, it stays high until reset.
- R8: A final boot message received by an application processor has no effect; `start_fw` stays 0.
- R9: An application processor that is waiting and receives a startup message (type 2, mode 110) latches the vector into `ap_vector`, pulses `start_ap` for one cycle, and moves to a running state. A startup message arriving in any other state, or with any other mode, changes nothing.
- R10: While `tx_req` is high and `tx_ready` is low, `tx_req`, `tx_type` and `tx_vector` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| node_id | input | 4 | This node's identifier; static after reset |
| bist_done | input | 1 | Self-test complete |
| rx_valid | input | 1 | A bus message is present this cycle |
| rx_type | input | 2 | Message kind: 0 election, 1 final boot, 2 startup |
| rx_vector | input | 8 | Message vector |
| rx_src | input | 4 | Identifier of the sending node |
| rx_dmode | input | 3 | Delivery mode code |
| tx_ready | input | 1 | Bus accepts the pending request this cycle |
| tx_req | output | 1 | Transmit request, held until accepted |
| tx_type | output | 2 | Kind of the message being requested |
| tx_vector | output | 8 | Vector of the message being requested |
| tx_dmode | output | 3 | Delivery mode of the message being requested |
| is_bsp | output | 1 | Node is the elected boot processor |
| is_ap | output | 1 | Node is an application processor |
| start_fw | output | 1 | Boot processor may start firmware |
| start_ap | output | 1 | One-cycle pulse when an application processor is started |
| ap_vector | output | 8 | Start vector latched from the startup message |

## Verification
Some properties are checked by assertions on every cycle. A node never holds both roles, the boot role is never lost, firmware start only appears together with the boot role, and the start pulse lasts one cycle. A pending transmit keeps its fields until it is accepted, and no election request ever carries identifier Fh. Other behaviour can only be shown by the bench's scenarios, because it depends on the order of messages on the bus. These scenarios cover: the first-arrival rule, later election messages being ignored, each way an election message can be malformed, the final boot message coming back before firmware start, and startup messages sent to nodes in the wrong state or with the wrong mode.

// File: rtl/boot_elect_pkg.sv
package boot_elect_pkg;
  localparam int ID_W  = 4;
  localparam int VEC_W = 8;
  localparam int DM_W  = 3;
  localparam int TY_W  = 2;

  localparam logic [VEC_W-ID_W-1:0] GEN_TAG   = 4'h4;
  localparam logic [ID_W-1:0]       BAD_ID    = '1;
  localparam logic [VEC_W-1:0]      FINAL_VEC = 8'h10;
  localparam logic [DM_W-1:0]       DM_FIXED  = 3'b000;
  localparam logic [DM_W-1:0]       DM_START  = 3'b110;

  typedef enum logic [TY_W-1:0] {
    MT_ELECT = 2'd0,
    MT_FINAL = 2'd1,
    MT_START = 2'd2
  } msg_type_e;

  typedef enum logic [2:0] {
    RS_OPEN     = 3'd0,
    RS_BSP_SEND = 3'd1,
    RS_BSP_WAIT = 3'd2,
    RS_BSP_RUN  = 3'd3,
    RS_AP_WAIT  = 3'd4,
    RS_AP_RUN   = 3'd5
  } role_state_e;
endpackage

// File: rtl/boot_elect_rstsync.sv
module boot_elect_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/boot_elect_rx.sv
module boot_elect_rx
  import boot_elect_pkg::*;
(
  input  logic [ID_W-1:0]  node_id,
  input  logic             rx_valid,
  input  logic [TY_W-1:0]  rx_type,
  input  logic [VEC_W-1:0] rx_vector,
  input  logic [ID_W-1:0]  rx_src,
  input  logic [DM_W-1:0]  rx_dmode,
  output logic             elect_hit,
  output logic             elect_mine,
  output logic             final_hit,
  output logic             start_hit
);
  logic [ID_W-1:0]       vec_id;
  logic [VEC_W-ID_W-1:0] vec_gen;

  assign vec_id  = rx_vector[ID_W-1:0];
  assign vec_gen = rx_vector[VEC_W-1:ID_W];

  always_comb begin
    elect_hit = rx_valid && (rx_type == MT_ELECT) && (rx_dmode == DM_FIXED)
             && (vec_gen == GEN_TAG) && (vec_id != BAD_ID) && (rx_src == vec_id);
    elect_mine = elect_hit && (vec_id == node_id);
    final_hit  = rx_valid && (rx_type == MT_FINAL) && (rx_dmode == DM_FIXED)
              && (rx_vector == FINAL_VEC);
    start_hit  = rx_valid && (rx_type == MT_START) && (rx_dmode == DM_START);
  end
endmodule

// File: rtl/boot_elect_tx.sv
module boot_elect_tx
  import boot_elect_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  node_id,
  input  logic             bist_done,
  input  logic             final_go,
  input  logic             tx_ready,
  output logic             tx_req,
  output logic [TY_W-1:0]  tx_type,
  output logic [VEC_W-1:0] tx_vector,
  output logic [DM_W-1:0]  tx_dmode
);
  logic             launched_q, launched_d;
  logic             elect_pend_q, elect_pend_d;
  logic             final_pend_q, final_pend_d;
  logic [VEC_W-1:0] elect_vec_q, elect_vec_d;
  logic             launch_ok, accept;

  assign launch_ok = bist_done && !launched_q && (node_id != BAD_ID);
  assign tx_req    = elect_pend_q || final_pend_q;
  assign accept    = tx_req && tx_ready;

  always_comb begin
    launched_d   = launched_q;
    elect_pend_d = elect_pend_q;
    final_pend_d = final_pend_q;
    elect_vec_d  = elect_vec_q;
    if (launch_ok) begin
      launched_d   = 1'b1;
      elect_pend_d = 1'b1;
      elect_vec_d  = {GEN_TAG, node_id};
    end
    if (final_go) final_pend_d = 1'b1;
    if (accept) begin
      if (elect_pend_q) elect_pend_d = 1'b0;
      else              final_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launched_q   <= 1'b0;
      elect_pend_q <= 1'b0;
      final_pend_q <= 1'b0;
      elect_vec_q  <= '0;
    end else begin
      launched_q   <= launched_d;
      elect_pend_q <= elect_pend_d;
      final_pend_q <= final_pend_d;
      elect_vec_q  <= elect_vec_d;
    end
  end

  always_comb begin
    if (elect_pend_q) begin
      tx_type   = MT_ELECT;
      tx_vector = elect_vec_q;
    end else begin
      tx_type   = MT_FINAL;
      tx_vector = FINAL_VEC;
    end
    tx_dmode = DM_FIXED;
  end

  // R10: a pending request holds its fields until accepted
  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_ready) |=> (tx_req && $stable(tx_type) && $stable(tx_vector)));

  // R3: no election request ever carries the illegal identifier
  a_r3_no_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_type == MT_ELECT) |-> (tx_vector[ID_W-1:0] != BAD_ID));

  // R2: only one election request per reset
  a_r2_single_elect: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_ready && tx_type == MT_ELECT) |=> !(tx_req && tx_type == MT_ELECT));
endmodule

// File: rtl/boot_elect_role.sv
module boot_elect_role
  import boot_elect_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             elect_hit,
  input  logic             elect_mine,
  input  logic             final_hit,
  input  logic             start_hit,
  input  logic [VEC_W-1:0] start_vec,
  output logic             final_go,
  output logic             is_bsp,
  output logic             is_ap,
  output logic             start_fw,
  output logic             start_ap,
  output logic [VEC_W-1:0] ap_vector
);
  role_state_e      state_q, state_d;
  logic [VEC_W-1:0] ap_vec_q, ap_vec_d;
  logic             pulse_q, pulse_d;

  always_comb begin
    state_d  = state_q;
    ap_vec_d = ap_vec_q;
    pulse_d  = 1'b0;
    final_go = 1'b0;
    unique case (state_q)
      RS_OPEN: if (elect_hit) state_d = elect_mine ? RS_BSP_SEND : RS_AP_WAIT;
      RS_BSP_SEND: begin
        final_go = 1'b1;
        state_d  = RS_BSP_WAIT;
      end
      RS_BSP_WAIT: if (final_hit) state_d = RS_BSP_RUN;
      RS_BSP_RUN:  state_d = RS_BSP_RUN;
      RS_AP_WAIT: if (start_hit) begin
        ap_vec_d = start_vec;
        pulse_d  = 1'b1;
        state_d  = RS_AP_RUN;
      end
      RS_AP_RUN:   state_d = RS_AP_RUN;
      default:     state_d = RS_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RS_OPEN;
      ap_vec_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      ap_vec_q <= ap_vec_d;
      pulse_q  <= pulse_d;
    end
  end

  assign is_bsp    = (state_q == RS_BSP_SEND) || (state_q == RS_BSP_WAIT) || (state_q == RS_BSP_RUN);
  assign is_ap     = (state_q == RS_AP_WAIT) || (state_q == RS_AP_RUN);
  assign start_fw  = (state_q == RS_BSP_RUN);
  assign start_ap  = pulse_q;
  assign ap_vector = ap_vec_q;

  // R4: roles are exclusive and never revert
  a_r4_one_role: assert property (@(posedge clk) disable iff (!rst_n) !(is_bsp && is_ap));
  a_r4_bsp_kept: assert property (@(posedge clk) disable iff (!rst_n) is_bsp |=> is_bsp);
  a_r4_ap_kept:  assert property (@(posedge clk) disable iff (!rst_n) is_ap |=> is_ap);

  // R7: firmware start only on the boot processor, and it is kept
  a_r7_fw_bsp:  assert property (@(posedge clk) disable iff (!rst_n) start_fw |-> is_bsp);
  a_r7_fw_kept: assert property (@(posedge clk) disable iff (!rst_n) start_fw |=> start_fw);

  // R9: start pulse is a single cycle, on an application processor
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n) start_ap |=> !start_ap);
  a_r9_pulse_ap:  assert property (@(posedge clk) disable iff (!rst_n) start_ap |-> is_ap);
endmodule

// File: rtl/boot_elect_node.sv
module boot_elect_node
  import boot_elect_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  node_id,
  input  logic        bist_done,
  input  logic        rx_valid,
  input  logic [1:0]  rx_type,
  input  logic [7:0]  rx_vector,
  input  logic [3:0]  rx_src,
  input  logic [2:0]  rx_dmode,
  input  logic        tx_ready,
  output logic        tx_req,
  output logic [1:0]  tx_type,
  output logic [7:0]  tx_vector,
  output logic [2:0]  tx_dmode,
  output logic        is_bsp,
  output logic        is_ap,
  output logic        start_fw,
  output logic        start_ap,
  output logic [7:0]  ap_vector
);
  logic rst_sync_n;
  logic elect_hit, elect_mine, final_hit, start_hit, final_go;

  boot_elect_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  boot_elect_rx u_rx (
    .node_id(node_id), .rx_valid(rx_valid), .rx_type(rx_type),
    .rx_vector(rx_vector), .rx_src(rx_src), .rx_dmode(rx_dmode),
    .elect_hit(elect_hit), .elect_mine(elect_mine),
    .final_hit(final_hit), .start_hit(start_hit)
  );

  boot_elect_tx u_tx (
    .clk(clk), .rst_n(rst_sync_n), .node_id(node_id), .bist_done(bist_done),
    .final_go(final_go), .tx_ready(tx_ready), .tx_req(tx_req),
    .tx_type(tx_type), .tx_vector(tx_vector), .tx_dmode(tx_dmode)
  );

  boot_elect_role u_role (
    .clk(clk), .rst_n(rst_sync_n), .elect_hit(elect_hit), .elect_mine(elect_mine),
    .final_hit(final_hit), .start_hit(start_hit), .start_vec(rx_vector),
    .final_go(final_go), .is_bsp(is_bsp), .is_ap(is_ap), .start_fw(start_fw),
    .start_ap(start_ap), .ap_vector(ap_vector)
  );

  // R8: a final boot message never starts firmware on an application processor
  a_r8_ap_no_fw: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_ap |=> !start_fw);
endmodule

// File: tb/sim_boot_elect_node.sv
module sim_boot_elect_node;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] node_id;
  logic       bist_done, rx_valid, tx_ready;
  logic [1:0] rx_type;
  logic [7:0] rx_vector;
  logic [3:0] rx_src;
  logic [2:0] rx_dmode;
  logic       tx_req, is_bsp, is_ap, start_fw, start_ap;
  logic [1:0] tx_type;
  logic [7:0] tx_vector, ap_vector;
  logic [2:0] tx_dmode;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  boot_elect_node u0 (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .bist_done(bist_done),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_vector(rx_vector),
    .rx_src(rx_src), .rx_dmode(rx_dmode), .tx_ready(tx_ready),
    .tx_req(tx_req), .tx_type(tx_type), .tx_vector(tx_vector), .tx_dmode(tx_dmode),
    .is_bsp(is_bsp), .is_ap(is_ap), .start_fw(start_fw), .start_ap(start_ap),
    .ap_vector(ap_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      finish_up();
    end
  end

  task automatic do_reset(input logic [3:0] id);
    rst_n = 1'b0; node_id = id; bist_done = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
    rx_type = 2'd0; rx_vector = 8'h00; rx_src = 4'h0; rx_dmode = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_msg(input logic [1:0] t, input logic [7:0] v,
                          input logic [3:0] s, input logic [2:0] dm);
    rx_valid = 1'b1; rx_type = t; rx_vector = v; rx_src = s; rx_dmode = dm;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic grab_tx(output logic got, output logic [1:0] t,
                         output logic [7:0] v, output logic [2:0] dm);
    got = 1'b0; t = 2'd3; v = 8'hxx; dm = 3'bxxx;
    for (int i = 0; i < 20 && !got; i++) begin
      if (tx_req) begin
        got = 1'b1; t = tx_type; v = tx_vector; dm = tx_dmode;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; node_id = 4'h3; bist_done = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
    rx_type = 2'd0; rx_vector = 8'h00; rx_src = 4'h0; rx_dmode = 3'b000;
    repeat (3) @(negedge clk);
    chk("R1 bsp in reset", is_bsp, 0);
    chk("R1 req in reset", tx_req, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs after reset", {is_bsp, is_ap, start_fw, start_ap, tx_req}, 0);
    chk("R1 vector after reset", ap_vector, 8'h00);
  endtask

  task automatic t_bsp_path();
    logic got; logic [1:0] t; logic [7:0] v; logic [2:0] dm;
    do_reset(4'h3);
    bist_done = 1'b1;
    grab_tx(got, t, v, dm);
    chk("R2 election sent", {got, t, v, dm}, {1'b1, 2'd0, 8'h43, 3'b000});
    repeat (3) @(negedge clk);
    chk("R2 single election", tx_req, 0);
    send_msg(2'd0, 8'h43, 4'h3, 3'b000);
    chk("R4 own vector wins", {is_bsp, is_ap}, 2'b10);
    grab_tx(got, t, v, dm);
    chk("R6 final sent", {got, t, v, dm}, {1'b1, 2'd1, 8'h10, 3'b000});
    send_msg(2'd0, 8'h45, 4'h5, 3'b000);
    chk("R4 later election ignored", {is_bsp, is_ap}, 2'b10);
    chk("R7 no fw before final returns", start_fw, 0);
    send_msg(2'd1, 8'h10, 4'h3, 3'b000);
    chk("R7 fw after final returns", start_fw, 1);
    send_msg(2'd2, 8'h77, 4'h3, 3'b110);
    chk("R9 startup ignored on bsp", {start_ap, ap_vector}, {1'b0, 8'h00});
    repeat (2) @(negedge clk);
    chk("R7 fw kept", start_fw, 1);
  endtask

  task automatic t_ap_path();
    logic got; logic [1:0] t; logic [7:0] v; logic [2:0] dm; logic [7:0] v0;
    do_reset(4'h5);
    bist_done = 1'b1;
    @(negedge clk);
    v0 = tx_vector;
    repeat (3) @(negedge clk);
    chk("R10 req held while not ready", {tx_req, tx_vector}, {1'b1, v0});
    grab_tx(got, t, v, dm);
    chk("R2 election vector", v, 8'h45);
    send_msg(2'd0, 8'h42, 4'h2, 3'b000);
    chk("R4 other vector makes ap", {is_bsp, is_ap}, 2'b01);
    send_msg(2'd0, 8'h45, 4'h5, 3'b000);
    chk("R4 own later vector ignored", {is_bsp, is_ap}, 2'b01);
    send_msg(2'd1, 8'h10, 4'h2, 3'b000);
    chk("R8 final ignored on ap", start_fw, 0);
    send_msg(2'd2, 8'hA7, 4'h2, 3'b000);
    chk("R9 wrong mode ignored", {start_ap, ap_vector}, {1'b0, 8'h00});
    send_msg(2'd2, 8'hA7, 4'h2, 3'b110);
    chk("R9 startup pulse and vector", {start_ap, ap_vector}, {1'b1, 8'hA7});
    @(negedge clk);
    chk("R9 pulse one cycle", start_ap, 0);
    send_msg(2'd2, 8'h33, 4'h2, 3'b110);
    chk("R9 second startup ignored", {start_ap, ap_vector}, {1'b0, 8'hA7});
  endtask

  task automatic t_bad_id_and_filter();
    int seen = 0;
    do_reset(4'hF);
    bist_done = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_req) seen++;
    end
    chk("R3 id F sends nothing", seen, 0);
    send_msg(2'd0, 8'h4F, 4'hF, 3'b000);
    send_msg(2'd0, 8'h52, 4'h2, 3'b000);
    send_msg(2'd0, 8'h43, 4'h3, 3'b110);
    send_msg(2'd0, 8'h43, 4'h6, 3'b000);
    chk("R5 malformed elections ignored", {is_bsp, is_ap}, 2'b00);
    send_msg(2'd2, 8'h99, 4'h3, 3'b110);
    chk("R9 startup ignored while undecided", {start_ap, ap_vector, is_ap}, {1'b0, 8'h00, 1'b0});
    send_msg(2'd0, 8'h43, 4'h3, 3'b000);
    chk("R5 valid election decides", {is_bsp, is_ap}, 2'b01);
  endtask

  initial begin
    t_reset();
    t_bsp_path();
    t_ap_path();
    t_bad_id_and_filter();
    finish_up();
  end
endmodule